// File: doc/BRIEF.md
# Lookup Violation Capture Unit

This unit sits beside a forwarding table and records the exceptions that table raises during lookups. The table reports four kinds of exception: an entry that aged out, a member violation, a miss and a full-table condition. Each arrives as a one-cycle event that carries the MAC address involved, the number of the port the frame came in on, and a port vector. The unit holds one such record, raises an interrupt toward the host, and keeps both until software collects the record.

Software collects the record with a get-and-clear command. It writes the command into the operation register with the busy bit set, then polls until the busy bit drops. At that point the operation register shows which kind of violation was captured and whether further events were lost. The data register holds the source port and the port vector. The three MAC registers hold the address. The pending state and the interrupt are cleared in the same step. An event that arrives in the cycle the command completes becomes the next pending record, so it is not lost.

Top module: `lookup_viol_unit`

## Requirements
- R1: After reset, `irq` is 0 and every register (operation 0, data 1, MAC high 2, MAC middle 3, MAC low 4) reads as 0.
- R2: An `ev_valid` pulse while nothing is pending makes `irq` 1 from the next cycle onward.
- R3: Writing the operation register with bit 15 (busy) set and bits 14:12 equal to 3'b110 (get-and-clear) starts the command. Bit 15 then reads 1 for exactly OP_LAT cycles and then reads 0.
- R4: An operation-register write that has bit 15 clear, or an opcode other than 3'b110, starts nothing. Busy stays 0, the pending record and `irq` are kept, and bits 14:12 still show the last accepted opcode.
- R5: After get-and-clear, the operation register shows the captured kind as a single flag. Kind `ev_kind` 0 (age-out) sets bit 7, 1 (member) sets bit 6, 2 (miss) sets bit 5 and 3 (full) sets bit 4. The data register holds the source port in bits 3:0 and the port vector in bits 4+NPORTS-1:4.
- R6: After get-and-clear, the MAC high register holds `ev_mac[47:32]`, the middle register holds `ev_mac[31:16]` and the low register holds `ev_mac[15:0]`.
- R7: While a record is pending, later events do not change it. Operation-register bit 3 (overflow) is set after the next get-and-clear if any event was dropped, and is cleared otherwise.
- R8: `irq` falls in the cycle after the completing clock edge of get-and-clear. A get-and-clear with nothing pending reads back zero flags, zero overflow, zero data and zero MAC.
- R9: An event that arrives in the cycle in which get-and-clear completes becomes the new pending record, and `irq` stays 1.
- R10: A get-and-clear write issued while busy is ignored, and the running command still ends after OP_LAT cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | One-cycle violation event strobe |
| ev_kind | input | 2 | Violation kind: 0 age-out, 1 member, 2 miss, 3 full |
| ev_mac | input | 48 | MAC address involved in the violation |
| ev_port | input | PORT_W | Source port number |
| ev_pvec | input | NPORTS | Port vector of the event |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe, data one cycle later |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |
| irq | output | 1 | Violation pending interrupt |

## Verification
Random bursts of zero to three events, spaced by random gaps and followed by a get-and-clear, check three things. The first event in a burst must be the one reported. Overflow must be set exactly when the burst had more than one event. An empty burst must read back all zeros. Random kinds, ports, vectors and addresses check that each field lands in its own bit position. Directed cases then test the edges of the busy window:
- an event placed on the completing edge, which must survive;
- a second command written during the busy window, which must neither restart nor stretch it;
- writes with the wrong opcode or without the busy bit, which must leave the pending record untouched.

// File: rtl/lvu_pkg.sv
package lvu_pkg;
  localparam int REG_W = 16;
  localparam int MAC_W = 48;
  localparam int ADDR_W = 3;
  localparam int PV_LSB = 4;

  typedef enum logic [1:0] {
    VK_AGE    = 2'd0,
    VK_MEMBER = 2'd1,
    VK_MISS   = 2'd2,
    VK_FULL   = 2'd3
  } viol_kind_e;

  typedef enum logic [ADDR_W-1:0] {
    RA_OP      = 3'd0,
    RA_DATA    = 3'd1,
    RA_MAC_HI  = 3'd2,
    RA_MAC_MID = 3'd3,
    RA_MAC_LO  = 3'd4
  } reg_addr_e;

  localparam logic [2:0] OPC_GETCLR = 3'b110;
  localparam int BUSY_BIT = 15;
  localparam int OVF_BIT = 3;
endpackage

// File: rtl/lvu_capture.sv
module lvu_capture
  import lvu_pkg::*;
#(
  parameter int NPORTS = 11,
  parameter int PORT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_valid,
  input  viol_kind_e        ev_kind,
  input  logic [MAC_W-1:0]  ev_mac,
  input  logic [PORT_W-1:0] ev_port,
  input  logic [NPORTS-1:0] ev_pvec,
  input  logic              clr,
  output logic              pend,
  output logic              ovf,
  output viol_kind_e        rec_kind,
  output logic [MAC_W-1:0]  rec_mac,
  output logic [PORT_W-1:0] rec_port,
  output logic [NPORTS-1:0] rec_pvec
);
  // The record is taken when the slot is free, or when the slot is
  // being emptied by get-and-clear in this same cycle.
  logic take;
  assign take = ev_valid && (!pend || clr);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0;
      ovf  <= 1'b0;
    end else if (clr) begin
      pend <= ev_valid;
      ovf  <= 1'b0;
    end else if (ev_valid) begin
      if (pend) ovf <= 1'b1;
      pend <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rec_kind <= VK_AGE;
      rec_mac  <= '0;
      rec_port <= '0;
      rec_pvec <= '0;
    end else if (take) begin
      rec_kind <= ev_kind;
      rec_mac  <= ev_mac;
      rec_port <= ev_port;
      rec_pvec <= ev_pvec;
    end
  end
endmodule

// File: rtl/lvu_opctl.sv
module lvu_opctl
  import lvu_pkg::*;
#(
  parameter int OP_LAT = 3
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic        wr_busy,
  input  logic [2:0]  wr_opc,
  output logic        busy,
  output logic        done,
  output logic [2:0]  opc_q
);
  localparam int CNT_W = (OP_LAT > 1) ? $clog2(OP_LAT) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(OP_LAT - 1);

  logic [CNT_W-1:0] cnt;
  logic start;

  assign start = wr_en && (wr_addr == RA_OP) && wr_busy &&
                 (wr_opc == OPC_GETCLR) && !busy;
  assign done = busy && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      cnt   <= '0;
      opc_q <= 3'b000;
    end else if (start) begin
      busy  <= 1'b1;
      cnt   <= CNT_LOAD;
      opc_q <= wr_opc;
    end else if (done) begin
      busy <= 1'b0;
    end else if (busy) begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/lvu_readout.sv
module lvu_readout
  import lvu_pkg::*;
#(
  parameter int NPORTS = 11,
  parameter int PORT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              pend,
  input  logic              ovf,
  input  viol_kind_e        rec_kind,
  input  logic [MAC_W-1:0]  rec_mac,
  input  logic [PORT_W-1:0] rec_port,
  input  logic [NPORTS-1:0] rec_pvec,
  input  logic              busy,
  input  logic [2:0]        opc_q,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [REG_W-1:0]  rdata
);
  localparam int NKIND = 4;

  logic [NKIND-1:0]  flag_nx;
  logic [NKIND-1:0]  snap_flags;
  logic              snap_ovf;
  logic [MAC_W-1:0]  snap_mac;
  logic [PORT_W-1:0] snap_port;
  logic [NPORTS-1:0] snap_pvec;
  logic [REG_W-1:0]  op_word;
  logic [REG_W-1:0]  data_word;

  // Flag for kind k sits at bit NKIND-1-k of the flag nibble.
  for (genvar k = 0; k < NKIND; k++) begin : g_flag
    assign flag_nx[NKIND-1-k] = pend && (rec_kind == viol_kind_e'(k));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      snap_flags <= '0;
      snap_ovf   <= 1'b0;
      snap_mac   <= '0;
      snap_port  <= '0;
      snap_pvec  <= '0;
    end else if (load) begin
      snap_flags <= flag_nx;
      snap_ovf   <= pend && ovf;
      snap_mac   <= pend ? rec_mac : '0;
      snap_port  <= pend ? rec_port : '0;
      snap_pvec  <= pend ? rec_pvec : '0;
    end
  end

  always_comb begin
    op_word = '0;
    op_word[BUSY_BIT] = busy;
    op_word[14:12] = opc_q;
    op_word[7:4] = snap_flags;
    op_word[OVF_BIT] = snap_ovf;
    data_word = '0;
    data_word[PORT_W-1:0] = snap_port;
    data_word[PV_LSB +: NPORTS] = snap_pvec;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      case (rd_addr)
        RA_OP:      rdata <= op_word;
        RA_DATA:    rdata <= data_word;
        RA_MAC_HI:  rdata <= snap_mac[47:32];
        RA_MAC_MID: rdata <= snap_mac[31:16];
        RA_MAC_LO:  rdata <= snap_mac[15:0];
        default:    rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/lookup_viol_unit.sv
module lookup_viol_unit
  import lvu_pkg::*;
#(
  parameter int NPORTS = 11,
  parameter int PORT_W = 4,
  parameter int OP_LAT = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_valid,
  input  logic [1:0]        ev_kind,
  input  logic [47:0]       ev_mac,
  input  logic [PORT_W-1:0] ev_port,
  input  logic [NPORTS-1:0] ev_pvec,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_addr,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  output logic              irq
);
  logic              op_busy;
  logic              op_done;
  logic [2:0]        op_opc;
  logic              cap_pend;
  logic              cap_ovf;
  viol_kind_e        cap_kind;
  logic [MAC_W-1:0]  cap_mac;
  logic [PORT_W-1:0] cap_port;
  logic [NPORTS-1:0] cap_pvec;
  logic              unused_wbits;

  assign unused_wbits = ^reg_wdata[11:0];

  lvu_opctl #(.OP_LAT(OP_LAT)) u_opctl (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (reg_wr),
    .wr_addr (reg_addr),
    .wr_busy (reg_wdata[BUSY_BIT]),
    .wr_opc  (reg_wdata[14:12]),
    .busy    (op_busy),
    .done    (op_done),
    .opc_q   (op_opc)
  );

  lvu_capture #(.NPORTS(NPORTS), .PORT_W(PORT_W)) u_capture (
    .clk      (clk),
    .rst      (rst),
    .ev_valid (ev_valid),
    .ev_kind  (viol_kind_e'(ev_kind)),
    .ev_mac   (ev_mac),
    .ev_port  (ev_port),
    .ev_pvec  (ev_pvec),
    .clr      (op_done),
    .pend     (cap_pend),
    .ovf      (cap_ovf),
    .rec_kind (cap_kind),
    .rec_mac  (cap_mac),
    .rec_port (cap_port),
    .rec_pvec (cap_pvec)
  );

  lvu_readout #(.NPORTS(NPORTS), .PORT_W(PORT_W)) u_readout (
    .clk      (clk),
    .rst      (rst),
    .load     (op_done),
    .pend     (cap_pend),
    .ovf      (cap_ovf),
    .rec_kind (cap_kind),
    .rec_mac  (cap_mac),
    .rec_port (cap_port),
    .rec_pvec (cap_pvec),
    .busy     (op_busy),
    .opc_q    (op_opc),
    .rd_en    (reg_rd),
    .rd_addr  (reg_addr),
    .rdata    (reg_rdata)
  );

  assign irq = cap_pend;
endmodule

// File: rtl/lvu_chk.sv
module lvu_chk #(
  parameter int PORT_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              ev_valid,
  input logic [47:0]       ev_mac,
  input logic              reg_wr,
  input logic [2:0]        reg_addr,
  input logic [15:0]       reg_wdata,
  input logic              irq,
  input logic              busy,
  input logic              done,
  input logic [47:0]       rec_mac,
  input logic [PORT_W-1:0] rec_port
);
  AST_EVENT_RAISES_IRQ: assert property (@(posedge clk) disable iff (rst)
    ev_valid |=> irq); // R2

  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> busy); // R3

  AST_BUSY_ENDS: assert property (@(posedge clk) disable iff (rst)
    done |=> !busy); // R3

  AST_BAD_CMD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!busy && reg_wr && reg_addr == 3'd0 &&
     (!reg_wdata[15] || reg_wdata[14:12] != 3'b110)) |=> !busy); // R4

  AST_RECORD_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (irq && !done) |=> ($stable(rec_mac) && $stable(rec_port))); // R7

  AST_IRQ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (done && !ev_valid) |=> !irq); // R8

  AST_SAME_CYCLE_KEPT: assert property (@(posedge clk) disable iff (rst)
    (done && ev_valid) |=> (irq && rec_mac == $past(ev_mac))); // R9
endmodule

bind lookup_viol_unit lvu_chk #(.PORT_W(PORT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ev_valid  (ev_valid),
  .ev_mac    (ev_mac),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .irq       (irq),
  .busy      (op_busy),
  .done      (op_done),
  .rec_mac   (cap_mac),
  .rec_port  (cap_port)
);

// File: tb/lookup_viol_unit_bench.sv
`timescale 1ns/1ps
module lookup_viol_unit_bench;
  localparam int NPORTS = 11;
  localparam int PORT_W = 4;
  localparam int OP_LAT = 3;
  localparam logic [15:0] GC_CMD = 16'hE000; // busy=1, opcode 3'b110

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ev_valid = 1'b0;
  logic [1:0] ev_kind = '0;
  logic [47:0] ev_mac = '0;
  logic [PORT_W-1:0] ev_port = '0;
  logic [NPORTS-1:0] ev_pvec = '0;
  logic reg_wr = 1'b0;
  logic reg_rd = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic irq;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  // expected first-captured record
  bit e_valid;
  bit e_ovf;
  logic [1:0] e_kind;
  logic [47:0] e_mac;
  logic [PORT_W-1:0] e_port;
  logic [NPORTS-1:0] e_pvec;

  always #2 clk = ~clk;

  lookup_viol_unit #(.NPORTS(NPORTS), .PORT_W(PORT_W), .OP_LAT(OP_LAT))
    u_lookup_viol_unit (
    .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_kind(ev_kind),
    .ev_mac(ev_mac), .ev_port(ev_port), .ev_pvec(ev_pvec),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

  function automatic logic [15:0] exp_op(bit v, logic [1:0] k, bit o, bit any_cmd);
    logic [15:0] w;
    w = any_cmd ? 16'h6000 : 16'h0000;
    if (v) w = w | (16'h0080 >> k);
    if (v && o) w = w | 16'h0008;
    return w;
  endfunction

  function automatic logic [15:0] exp_data(bit v, logic [PORT_W-1:0] p, logic [NPORTS-1:0] pv);
    logic [15:0] w;
    w = '0;
    if (v) begin
      w[PORT_W-1:0] = p;
      w[4 +: NPORTS] = pv;
    end
    return w;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(logic [2:0] a, output logic [15:0] v);
    reg_rd = 1'b1;
    reg_addr = a;
    @(negedge clk);
    v = reg_rdata;
    reg_rd = 1'b0;
  endtask

  task automatic send_ev(logic [1:0] k, logic [47:0] m, logic [PORT_W-1:0] p,
                         logic [NPORTS-1:0] pv);
    ev_valid = 1'b1; ev_kind = k; ev_mac = m; ev_port = p; ev_pvec = pv;
    if (!e_valid) begin
      e_valid = 1'b1; e_kind = k; e_mac = m; e_port = p; e_pvec = pv;
    end else begin
      e_ovf = 1'b1;
    end
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  task automatic clear_model();
    e_valid = 1'b0; e_ovf = 1'b0; e_kind = '0; e_mac = '0; e_port = '0; e_pvec = '0;
  endtask

  // Issue get-and-clear, poll busy, then check every register against the model.
  task automatic gc_poll_check(string tag);
    int n;
    logic [15:0] v;
    reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = GC_CMD;
    @(negedge clk);
    reg_wr = 1'b0; reg_rd = 1'b1; reg_addr = 3'd0;
    n = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (reg_rdata[15]) n++;
      else break;
    end
    v = reg_rdata;
    reg_rd = 1'b0;
    chk({"R3 busy cycles ", tag}, n, OP_LAT);
    chk({"R5 R7 op word ", tag}, v, exp_op(e_valid, e_kind, e_ovf, 1'b1));
    chk({"R8 irq after clear ", tag}, irq, 1'b0);
    rd(3'd1, v);
    chk({"R5 data word ", tag}, v, exp_data(e_valid, e_port, e_pvec));
    rd(3'd2, v);
    chk({"R6 mac hi ", tag}, v, e_valid ? e_mac[47:32] : 16'h0);
    rd(3'd3, v);
    chk({"R6 mac mid ", tag}, v, e_valid ? e_mac[31:16] : 16'h0);
    rd(3'd4, v);
    chk({"R6 mac lo ", tag}, v, e_valid ? e_mac[15:0] : 16'h0);
    clear_model();
  endtask

  // Timed get-and-clear: checks the exact irq fall edge; optional event on
  // the completing edge and optional repeated command while busy.
  task automatic gc_timed(bit inject, bit rewrite, logic [1:0] k, logic [47:0] m,
                          logic [PORT_W-1:0] p, logic [NPORTS-1:0] pv, string tag);
    reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = GC_CMD;
    @(negedge clk);
    reg_wr = rewrite;
    for (int i = 1; i < OP_LAT; i++) begin
      @(negedge clk);
      reg_wr = 1'b0;
    end
    reg_wr = 1'b0;
    chk({"R8 irq before completion ", tag}, irq, 1'b1);
    if (inject) begin
      ev_valid = 1'b1; ev_kind = k; ev_mac = m; ev_port = p; ev_pvec = pv;
    end
    @(negedge clk);
    ev_valid = 1'b0;
    chk({inject ? "R9 irq kept " : "R8 R10 irq falls ", tag}, irq, inject);
  endtask

  initial begin
    #(4ns * 150000);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    void'($urandom(32'd20240611));
    clear_model();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq at reset", irq, 1'b0);
    chk("R1 rdata at reset", reg_rdata, 16'h0);
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v);
      chk("R1 register at reset", v, 16'h0);
    end
    begin
      // first command ever: nothing pending, opcode bits become 110
      gc_poll_check("empty first R8");
    end

    // random bursts
    for (int t = 0; t < 40; t++) begin
      int k;
      k = $urandom_range(0, 3);
      for (int e = 0; e < k; e++) begin
        send_ev(2'($urandom_range(0, 3)), {$urandom(), 16'($urandom())},
                PORT_W'($urandom_range(0, NPORTS - 1)), NPORTS'($urandom()));
        repeat ($urandom_range(0, 3)) @(negedge clk);
      end
      chk("R2 R7 irq follows burst", irq, (k > 0));
      gc_poll_check("random");
    end

    // R4 ignored writes keep the record
    send_ev(2'd2, 48'h0102_0304_0506, 4'd5, 11'h155);
    reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 16'h9000;
    @(negedge clk);
    reg_wdata = 16'h6000;
    @(negedge clk);
    reg_wr = 1'b0;
    chk("R4 irq kept after bad writes", irq, 1'b1);
    rd(3'd0, v);
    chk("R4 busy stays 0", v[15], 1'b0);
    chk("R4 opcode field unchanged", v[14:12], 3'b110);
    gc_poll_check("after R4");

    // R9 event on the completing edge
    send_ev(2'd0, 48'hAAAA_BBBB_CCCC, 4'd1, 11'h001);
    gc_timed(1'b1, 1'b0, 2'd3, 48'h1111_2222_3333, 4'd10, 11'h7FF, "edge");
    rd(3'd0, v);
    chk("R9 first record reported", v, exp_op(1'b1, 2'd0, 1'b0, 1'b1));
    clear_model();
    e_valid = 1'b1; e_kind = 2'd3; e_mac = 48'h1111_2222_3333;
    e_port = 4'd10; e_pvec = 11'h7FF;
    gc_poll_check("R9 second");

    // R10 write while busy ignored
    send_ev(2'd1, 48'hDEAD_BEEF_0042, 4'd7, 11'h2A0);
    gc_timed(1'b0, 1'b1, 2'd0, 48'h0, 4'd0, 11'h0, "rewrite");
    rd(3'd0, v);
    chk("R10 busy clear after rewrite", v[15], 1'b0);
    chk("R10 record reported", v, exp_op(1'b1, 2'd1, 1'b0, 1'b1));
    clear_model();

    // R7 directed overflow, back-to-back
    send_ev(2'd1, 48'h0000_0000_0001, 4'd2, 11'h004);
    send_ev(2'd3, 48'hFFFF_FFFF_FFFF, 4'd9, 11'h7FF);
    gc_poll_check("R7 back to back");

    // R8 empty get-and-clear
    gc_poll_check("R8 empty");

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule